// File: doc/BRIEF.md
# Host-Accessible Variable Table with Batched Commit

This block is the host-facing side of a hosted design. It keeps a table of data words that stands for the hosted design's inputs and registered state. The host drives a read strobe, a write strobe, a word index and a data word. It sees a combinational output word and a wait flag. A strobe that is held high counts as one request, taken in its first cycle only.

A read request at an ordinary index loads the data word into that table entry. A small group of reserved indices sits just above the table, and a read request there issues a command instead:

- commit the pending state updates;
- re-baseline the update tracking;
- resume execution;
- set or clear one end-of-file flag;
- return the pending-update summary.

The hosted logic marks a state word as changed by toggling that word's bit in a current update mask. It also presents the new value on a shadow bus. The block compares this mask with the baseline mask it keeps. A commit copies the shadow value into every flagged word in one cycle and then moves the baseline up to the current mask.

Top module: `mvt_host_slave`

## Requirements
- R1: A read request exists only in a cycle where the read strobe is high after being low in the previous cycle. A write request is found the same way from the write strobe. A strobe held high for several cycles gives one request.
- R2: A read request whose index is below the table size NUM_WORDS stores the input word in the table entry at that index.
- R3: The pending vector is the baseline mask XOR the current mask, taken over all MASK_W bits. A read at the status index (NUM_WORDS+4) returns the OR of the pending vector in bit 0, with all other bits zero.
- R4: When updates are applied, table word i takes shadow word i if pending bit i is set. A word whose pending bit is clear keeps its value.
- R5: The baseline mask takes the current mask in a cycle where updates are applied or a tracking reset occurs. In every other cycle it holds its value.
- R6: A read request at the reset index (NUM_WORDS+1) is a tracking reset. It clears the pending vector and leaves the table unchanged.
- R7: Updates are applied on a read request at the commit index (NUM_WORDS+0). They are also applied in a cycle where the step input is high and some pending bit is set.
- R8: A read request at the end-of-file index (NUM_WORDS+3) writes bit 0 of the input word into flag number din[7:1] of a 128-flag array that is visible on an output.
- R9: The output is combinational. An index below NUM_WORDS returns that table entry. Any other index except the status index returns zero.
- R10: The wait output is high when any of these holds: a read request, a write request, the step input, the trigger input, or the continue condition. The continue condition is a read request at the resume index (NUM_WORDS+2), or all_final low together with tasks_seen low.
- R11: The table holds max(16, NUM_VARS) words. The masks are max(32, NUM_WORDS) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_strobe | input | 1 | Host read strobe, level |
| wr_strobe | input | 1 | Host write strobe, level |
| index | input | IDX_W | Word index or command index |
| din | input | DATA_W | Host input data word |
| dout | output | DATA_W | Selected table word or status |
| wait_o | output | 1 | Host must wait this cycle |
| cur_mask | input | MASK_W | Current toggle mask from the hosted logic |
| shadow_flat | input | NUM_WORDS*DATA_W | Shadow values, word i at bits i*DATA_W upward |
| step_i | input | 1 | Free-running step of the hosted logic |
| trigger_i | input | 1 | Clock edge seen by the hosted logic |
| all_final_i | input | 1 | All hosted tasks are in their final state |
| tasks_seen_i | input | 1 | Hosted logic raised a task |
| eof_flags | output | 128 | End-of-file flag array |

## Verification
The bench builds the block with NUM_VARS = 10 and DATA_W = 32. This makes both size floors take effect: the table is padded to 16 words, and the masks are widened to 32 bits. Because of that, a padding word (index 15) can be written directly. A mask bit beyond the table (bit 20) can be shown to raise the pending summary without touching any word. The reserved indices then land at 16 to 20, so the first of them is also the first index that no longer writes the table.

// File: rtl/mvt_pkg.sv
package mvt_pkg;

  // Offsets of the command indices above the table
  typedef enum int unsigned {
    CMD_COMMIT = 0,
    CMD_RESET  = 1,
    CMD_RESUME = 2,
    CMD_EOF    = 3,
    CMD_PEND   = 4,
    CMD_COUNT  = 5
  } cmd_off_e;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mvt_edge_detect.sv
module mvt_edge_detect #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] pulse
);

  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b0;
      else        prev_q[g] <= lvl[g];
    end
    assign pulse[g] = lvl[g] & ~prev_q[g];
  end

endmodule

// File: rtl/mvt_update_track.sv
module mvt_update_track #(
  parameter int unsigned MASK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MASK_W-1:0] cur_mask,
  input  logic              apply,
  input  logic              rebase,
  output logic [MASK_W-1:0] base_mask,
  output logic [MASK_W-1:0] pend,
  output logic              pend_any
);

  logic [MASK_W-1:0] base_d;
  logic              base_en;

  assign base_en = apply | rebase;

  always_comb begin
    base_d = base_mask;
    if (base_en) base_d = cur_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_mask <= '0;
    else        base_mask <= base_d;
  end

  assign pend     = base_mask ^ cur_mask;
  assign pend_any = |pend;

endmodule

// File: rtl/mvt_word_table.sv
module mvt_word_table #(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned AW       = $clog2(NUM_WORDS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              apply,
  input  logic [NUM_WORDS-1:0]              pend,
  input  logic [NUM_WORDS-1:0][DATA_W-1:0]  shadow,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  words
);

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic              hit;
    logic [DATA_W-1:0] word_d;

    assign hit = wr_en && (wr_addr == AW'(g));

    // A direct host write wins over a commit on the same word
    always_comb begin
      word_d = words[g];
      if (apply && pend[g]) word_d = shadow[g];
      if (hit)              word_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= '0;
      else        words[g] <= word_d;
    end
  end

endmodule

// File: rtl/mvt_host_slave.sv
module mvt_host_slave
  import mvt_pkg::*;
#(
  parameter int unsigned NUM_VARS  = 16,
  parameter int unsigned DATA_W    = 32,
  localparam int unsigned NUM_WORDS = max_u(16, NUM_VARS),
  localparam int unsigned MASK_W    = max_u(32, NUM_WORDS),
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS + CMD_COUNT),
  localparam int unsigned AW        = $clog2(NUM_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_strobe,
  input  logic                        wr_strobe,
  input  logic [IDX_W-1:0]            index,
  input  logic [DATA_W-1:0]           din,
  output logic [DATA_W-1:0]           dout,
  output logic                        wait_o,
  input  logic [MASK_W-1:0]           cur_mask,
  input  logic [NUM_WORDS*DATA_W-1:0] shadow_flat,
  input  logic                        step_i,
  input  logic                        trigger_i,
  input  logic                        all_final_i,
  input  logic                        tasks_seen_i,
  output logic [127:0]                eof_flags
);

  localparam logic [IDX_W-1:0] IX_COMMIT = IDX_W'(NUM_WORDS + CMD_COMMIT);
  localparam logic [IDX_W-1:0] IX_RESET  = IDX_W'(NUM_WORDS + CMD_RESET);
  localparam logic [IDX_W-1:0] IX_RESUME = IDX_W'(NUM_WORDS + CMD_RESUME);
  localparam logic [IDX_W-1:0] IX_EOF    = IDX_W'(NUM_WORDS + CMD_EOF);
  localparam logic [IDX_W-1:0] IX_PEND   = IDX_W'(NUM_WORDS + CMD_PEND);
  localparam logic [IDX_W-1:0] IX_TOP    = IDX_W'(NUM_WORDS);

  logic [1:0]                       req;
  logic                             rd_req, wr_req;
  logic                             in_table;
  logic                             cmd_commit, cmd_reset, cmd_resume, cmd_eof;
  logic                             apply, cont;
  logic [MASK_W-1:0]                base_mask, pend;
  logic                             pend_any;
  logic [NUM_WORDS-1:0][DATA_W-1:0] shadow, words;
  logic [NUM_WORDS*DATA_W-1:0]      words_flat;
  logic                             direct_any;
  logic [127:0]                     eof_d;

  mvt_edge_detect #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   ({wr_strobe, rd_strobe}),
    .pulse (req)
  );
  assign rd_req = req[0];
  assign wr_req = req[1];

  // Command decode
  assign in_table   = index < IX_TOP;
  assign cmd_commit = rd_req && (index == IX_COMMIT);
  assign cmd_reset  = rd_req && (index == IX_RESET);
  assign cmd_resume = rd_req && (index == IX_RESUME);
  assign cmd_eof    = rd_req && (index == IX_EOF);
  assign direct_any = rd_req && in_table;

  mvt_update_track #(.MASK_W(MASK_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_mask  (cur_mask),
    .apply     (apply),
    .rebase    (cmd_reset),
    .base_mask (base_mask),
    .pend      (pend),
    .pend_any  (pend_any)
  );

  assign apply = cmd_commit || (pend_any && step_i);

  assign shadow = shadow_flat;

  mvt_word_table #(.NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (direct_any),
    .wr_addr (index[AW-1:0]),
    .wr_data (din),
    .apply   (apply),
    .pend    (pend[NUM_WORDS-1:0]),
    .shadow  (shadow),
    .words   (words)
  );
  assign words_flat = words;

  // End-of-file flags
  always_comb begin
    eof_d = eof_flags;
    if (cmd_eof) eof_d[din[7:1]] = din[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eof_flags <= '0;
    else        eof_flags <= eof_d;
  end

  // Output selection
  always_comb begin
    dout = '0;
    if (index == IX_PEND)  dout = DATA_W'(pend_any);
    else if (in_table)     dout = words[index[AW-1:0]];
  end

  assign cont   = cmd_resume || (!all_final_i && !tasks_seen_i);
  assign wait_o = rd_req || wr_req || step_i || trigger_i || cont;

endmodule

// File: rtl/mvt_host_checker.sv
module mvt_host_checker #(
  parameter int unsigned MASK_W  = 32,
  parameter int unsigned FLAT_W  = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              wr_req,
  input logic              apply,
  input logic              cmd_reset,
  input logic              direct_any,
  input logic              wait_o,
  input logic [MASK_W-1:0] base_mask,
  input logic [MASK_W-1:0] cur_mask,
  input logic [FLAT_W-1:0] words_flat
);

  AST_READ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req); // R1

  AST_WAIT_ON_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_req) |-> wait_o); // R10

  AST_BASE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (apply || cmd_reset) |=> (base_mask == $past(cur_mask))); // R5

  AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply || cmd_reset) |=> $stable(base_mask)); // R5

  AST_TABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(apply || direct_any) |=> $stable(words_flat)); // R4

endmodule

bind mvt_host_slave mvt_host_checker #(
  .MASK_W (MASK_W),
  .FLAT_W (NUM_WORDS*DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .wr_req     (wr_req),
  .apply      (apply),
  .cmd_reset  (cmd_reset),
  .direct_any (direct_any),
  .wait_o     (wait_o),
  .base_mask  (base_mask),
  .cur_mask   (cur_mask),
  .words_flat (words_flat)
);

// File: tb/test_mvt_host_slave.sv
module test_mvt_host_slave;

  localparam int NW = 16;
  localparam int MW = 32;
  localparam int DW = 32;
  localparam int IW = 5;
  localparam logic [IW-1:0] IX_COMMIT = 5'd16;
  localparam logic [IW-1:0] IX_RESET  = 5'd17;
  localparam logic [IW-1:0] IX_RESUME = 5'd18;
  localparam logic [IW-1:0] IX_EOF    = 5'd19;
  localparam logic [IW-1:0] IX_PEND   = 5'd20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rd_strobe, wr_strobe;
  logic [IW-1:0]     index;
  logic [DW-1:0]     din;
  logic [DW-1:0]     dout;
  logic              wait_o;
  logic [MW-1:0]     cur_mask;
  logic [NW*DW-1:0]  shadow_flat;
  logic              step_i, trigger_i, all_final_i, tasks_seen_i;
  logic [127:0]      eof_flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mvt_host_slave #(.NUM_VARS(10), .DATA_W(32)) i_mvt_host_slave (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_strobe    (rd_strobe),
    .wr_strobe    (wr_strobe),
    .index        (index),
    .din          (din),
    .dout         (dout),
    .wait_o       (wait_o),
    .cur_mask     (cur_mask),
    .shadow_flat  (shadow_flat),
    .step_i       (step_i),
    .trigger_i    (trigger_i),
    .all_final_i  (all_final_i),
    .tasks_seen_i (tasks_seen_i),
    .eof_flags    (eof_flags)
  );

  function automatic logic [DW-1:0] shv(int i);
    return 32'hA500_0000 + 32'(i * 17);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic peek(logic [IW-1:0] ix, output logic [DW-1:0] val);
    @(negedge clk);
    index = ix;
    #1 val = dout;
  endtask

  task automatic rd_pulse(logic [IW-1:0] ix, logic [DW-1:0] d);
    @(negedge clk);
    index = ix; din = d; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] v;
    peek(5'd0, v);  chk("R9 reset word0", v, 0);
    peek(IX_PEND, v); chk("R3 reset summary", v, 0);
    chk("R10 reset wait idle", {31'd0, wait_o}, 0);
    chk("R8 reset eof flags", {31'd0, |eof_flags}, 0);
  endtask

  task automatic t_direct_write();
    logic [DW-1:0] v;
    rd_pulse(5'd3, 32'h1234_5678);
    peek(5'd3, v);  chk("R2 write word3", v, 32'h1234_5678);
    rd_pulse(5'd15, 32'hCAFE_0015);
    peek(5'd15, v); chk("R11 padding word15 writable", v, 32'hCAFE_0015);
    peek(IX_RESUME, v); chk("R9 reserved index reads zero", v, 0);
    peek(5'd25, v); chk("R9 index above reserved reads zero", v, 0);
  endtask

  task automatic t_held_strobe();
    logic [DW-1:0] v;
    @(negedge clk);
    index = 5'd4; din = 32'h0000_0044; rd_strobe = 1'b1;
    #1 chk("R10 wait on read request", {31'd0, wait_o}, 1);
    @(negedge clk);
    din = 32'h0000_0099;
    #1 chk("R1 no second request while held", {31'd0, wait_o}, 0);
    @(negedge clk);
    rd_strobe = 1'b0;
    peek(5'd4, v); chk("R1 held strobe stores first value only", v, 32'h0000_0044);
  endtask

  task automatic t_batch_commit();
    logic [DW-1:0] v;
    @(negedge clk);
    cur_mask[2] = ~cur_mask[2];
    cur_mask[5] = ~cur_mask[5];
    peek(IX_PEND, v); chk("R3 summary after toggles", v, 1);
    peek(5'd2, v); chk("R4 no change before commit", v, 0);
    rd_pulse(IX_COMMIT, 32'h0);
    peek(5'd2, v); chk("R4 word2 committed", v, shv(2));
    peek(5'd5, v); chk("R4 word5 committed", v, shv(5));
    peek(5'd3, v); chk("R4 word3 without pending bit kept", v, 32'h1234_5678);
    peek(IX_PEND, v); chk("R5 summary clear after commit", v, 0);
  endtask

  task automatic t_reset_then_commit();
    logic [DW-1:0] v;
    @(negedge clk);
    cur_mask[7] = ~cur_mask[7];
    rd_pulse(IX_RESET, 32'h0);
    peek(IX_PEND, v); chk("R6 reset command clears pending", v, 0);
    peek(5'd7, v); chk("R6 reset command leaves table", v, 0);
    @(negedge clk);
    cur_mask[8] = ~cur_mask[8];
    rd_pulse(IX_COMMIT, 32'h0);
    peek(5'd8, v); chk("R4 word8 committed after reset", v, shv(8));
    peek(5'd7, v); chk("R6 word7 dropped by reset", v, 0);
  endtask

  task automatic t_step_commit();
    logic [DW-1:0] v;
    @(negedge clk);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    peek(5'd1, v); chk("R7 step without pending changes nothing", v, 0);
    @(negedge clk);
    cur_mask[1] = ~cur_mask[1];
    step_i = 1'b1;
    #1 chk("R10 wait on step", {31'd0, wait_o}, 1);
    @(negedge clk);
    step_i = 1'b0;
    peek(5'd1, v); chk("R7 step commits pending word1", v, shv(1));
    peek(IX_PEND, v); chk("R5 summary clear after step", v, 0);
  endtask

  task automatic t_wide_mask();
    logic [DW-1:0] v;
    @(negedge clk);
    cur_mask[20] = ~cur_mask[20];
    peek(IX_PEND, v); chk("R11 mask bit20 raises summary", v, 1);
    rd_pulse(IX_COMMIT, 32'h0);
    peek(IX_PEND, v); chk("R3 summary clear after wide commit", v, 0);
    peek(5'd4, v); chk("R4 table untouched by bit20", v, 32'h0000_0044);
  endtask

  task automatic t_eof();
    rd_pulse(IX_EOF, (32'd10 << 1) | 32'd1);
    chk("R8 eof flag10 set", {31'd0, eof_flags[10]}, 1);
    chk("R8 only flag10 set", 32'($countones(eof_flags)), 1);
    rd_pulse(IX_EOF, (32'd10 << 1));
    chk("R8 eof flag10 cleared", {31'd0, eof_flags[10]}, 0);
  endtask

  task automatic t_wait_sources();
    @(negedge clk);
    index = IX_PEND; wr_strobe = 1'b1;
    #1 chk("R10 wait on write request", {31'd0, wait_o}, 1);
    @(negedge clk);
    #1 chk("R1 held write strobe one request", {31'd0, wait_o}, 0);
    wr_strobe = 1'b0;
    @(negedge clk);
    trigger_i = 1'b1;
    #1 chk("R10 wait on trigger", {31'd0, wait_o}, 1);
    @(negedge clk);
    trigger_i = 1'b0; all_final_i = 1'b0;
    #1 chk("R10 wait on continue condition", {31'd0, wait_o}, 1);
    @(negedge clk);
    tasks_seen_i = 1'b1;
    #1 chk("R10 continue masked by tasks_seen", {31'd0, wait_o}, 0);
    @(negedge clk);
    all_final_i = 1'b1; tasks_seen_i = 1'b0;
    index = IX_RESUME; rd_strobe = 1'b1;
    #1 chk("R10 wait on resume request", {31'd0, wait_o}, 1);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    rd_strobe = 1'b0; wr_strobe = 1'b0;
    index = '0; din = '0; cur_mask = '0;
    step_i = 1'b0; trigger_i = 1'b0;
    all_final_i = 1'b1; tasks_seen_i = 1'b0;
    for (int i = 0; i < NW; i++) shadow_flat[i*DW +: DW] = shv(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_direct_write();
    t_held_strobe();
    t_batch_commit();
    t_reset_then_commit();
    t_step_commit();
    t_wide_mask();
    t_eof();
    t_wait_sources();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule